// File: doc/BRIEF.md
# Filtered reference phase comparator

This block turns a loop phase detector into a measuring instrument for the time offset between two reference clocks of the same nominal frequency. A fast sampling clock times the distance from a rising edge of the first input, called A, to the next rising edge of the second input, called B. That distance is scaled to 1/512 of the A period, so one LSB is about 0.7 degrees. The scaled value is then smoothed by a first-order low-pass filter, and the filter output is published as a signed 16-bit status word.

A measurement-enable bit chooses what drives input A. When the bit is clear, A is the local loop feedback. When it is set, A is the reference that the master loop currently selects. B always comes from a standby reference chosen by its own select input. The status word is read one byte at a time. Reading the low byte captures the high byte, so the two halves of one value stay together. A result only means something when both inputs run at the same frequency. The time resolution depends on that frequency.

Top module: `ref_phase_meter`

## Requirements
- R1: When `meas_en_i` is 1, detector input A is `ref_clk_i[master_sel_i]`. When it is 0, A is `fb_clk_i`.
- R2: Detector input B is always `ref_clk_i[standby_sel_i]`.
- R3: Every rising edge of B produces one sample x = floor(lag*512/period) mod 512, read as 9-bit two's complement. Here lag is the number of ticks from the latest A rising edge to this B edge, and it is 0 when both edges land in the same cycle. Period is the number of ticks between the last two A rising edges. A positive x means B lags A.
- R4: A B edge half a period or more after the A edge wraps to a negative value. The status never leaves the range -256..255.
- R5: No sample is produced until two A rising edges have been seen since reset. Until then the status stays 0.
- R6: The filter keeps an accumulator with FILT_SHIFT fraction bits. On each sample, acc += (x*2^FILT_SHIFT - acc) >>> FILT_SHIFT. The status is floor(acc / 2^FILT_SHIFT) as a 16-bit two's-complement value.
- R7: While `meas_en_i` is 0, the accumulator is forced to 0. The status reads 0 from the cycle after the enable is seen low.
- R8: The status does not change while the enable is set and no sample is produced.
- R9: With `rd_addr_i`=0, `rd_data_o` is status[7:0]. A cycle with `rd_en_i`=1 and `rd_addr_i`=0 captures status[15:8]. With `rd_addr_i`=1, `rd_data_o` returns the captured byte.
- R10: After reset the status is 0 and the captured byte is 0.
- R11: An input level sampled at clock edge k takes effect on the status at clock edge k+SYNC_STAGES. Rising edges are detected after a SYNC_STAGES-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| meas_en_i | input | 1 | Measurement mode: A is the master reference |
| fb_clk_i | input | 1 | Local loop feedback clock |
| ref_clk_i | input | NUM_REFS | Reference clock inputs |
| master_sel_i | input | SEL_W | Index of the reference selected by the master loop |
| standby_sel_i | input | SEL_W | Index of the standby reference (input B) |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 1 | Byte select: 0 low byte, 1 captured high byte |
| rd_data_o | output | 8 | Read data byte |
| status_o | output | 16 | Filtered signed phase word |

## Verification
The assertions assume three things about the inputs. First, a sample only arrives after a nonzero A period has been measured. Second, the mode bit is a steady register level. Third, both selected clocks toggle slowly enough that the tick counter does not saturate between edges. The stimulus meets all three. It builds every reference as a square wave with a 40-tick period and a fixed delay. It changes the select and mode inputs only on the inactive clock edge. It holds a reference low only in the case that checks that nothing is sampled before two A edges.

// File: rtl/ref_phase_pkg.sv
package ref_phase_pkg;
    // fraction bits of one reference cycle (1/512 cycle per LSB)
    localparam int unsigned PH_BITS = 9;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned STAT_W  = 2 * BYTE_W;

    typedef logic signed [PH_BITS-1:0] ph_sample_t;
endpackage

// File: rtl/rpm_edge_sync.sv
module rpm_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sig_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.pipe[0] = sig_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            s_d.pipe[i] = s_q.pipe[i-1];
        end
        s_d.last = s_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign rise_o = s_q.pipe[STAGES-1] & ~s_q.last;
endmodule

// File: rtl/rpm_interval.sv
module rpm_interval
    import ref_phase_pkg::*;
#(
    parameter int unsigned CNT_W = 12,
    localparam int unsigned PER_W = CNT_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             a_rise_i,
    input  logic             b_rise_i,
    output logic             smp_vld_o,
    output ph_sample_t       smp_o,
    output logic [PER_W-1:0] period_o
);
    localparam int unsigned     DIV_W   = PER_W + PH_BITS;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] since;   // ticks since the last A edge
        logic [PER_W-1:0] period;  // ticks between the last two A edges
        logic             seen;    // one A edge observed
        logic             armed;   // period holds a real measurement
    } tmr_t;

    tmr_t t_d, t_q;
    logic [PER_W-1:0] lag;
    logic [DIV_W-1:0] scaled, divisor;

    always_comb begin
        t_d     = t_q;
        lag     = a_rise_i ? '0 : PER_W'(t_q.since) + PER_W'(1);
        scaled  = {lag, {PH_BITS{1'b0}}};
        divisor = {{PH_BITS{1'b0}}, (t_q.armed ? t_q.period : PER_W'(1))};
        smp_o   = PH_BITS'(scaled / divisor);

        if (a_rise_i) begin
            if (t_q.seen) begin
                t_d.period = PER_W'(t_q.since) + PER_W'(1);
                t_d.armed  = 1'b1;
            end
            t_d.seen  = 1'b1;
            t_d.since = '0;
        end else if (t_q.since != CNT_MAX) begin
            t_d.since = t_q.since + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) t_q <= '0;
        else         t_q <= t_d;
    end

    assign smp_vld_o = b_rise_i & t_q.armed;
    assign period_o  = t_q.period;
endmodule

// File: rtl/rpm_iir.sv
module rpm_iir
    import ref_phase_pkg::*;
#(
    parameter int unsigned OUT_W = 16,
    parameter int unsigned SHIFT = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             smp_vld_i,
    input  ph_sample_t       smp_i,
    output logic [OUT_W-1:0] y_o
);
    localparam int unsigned ACC_W = OUT_W + SHIFT;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } iir_t;

    iir_t f_d, f_q;
    logic signed [ACC_W-1:0] target, step;

    always_comb begin
        f_d    = f_q;
        target = ACC_W'(smp_i) <<< SHIFT;
        step   = ($signed(target) - $signed(f_q.acc)) >>> SHIFT;
        if (clear_i) begin
            f_d.acc = '0;
        end else if (smp_vld_i) begin
            f_d.acc = f_q.acc + step;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) f_q <= '0;
        else         f_q <= f_d;
    end

    assign y_o = OUT_W'($signed(f_q.acc) >>> SHIFT);
endmodule

// File: rtl/ref_phase_meter.sv
module ref_phase_meter
    import ref_phase_pkg::*;
#(
    parameter int unsigned NUM_REFS    = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = 12,
    parameter int unsigned FILT_SHIFT  = 4,
    localparam int unsigned SEL_W      = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                meas_en_i,
    input  logic                fb_clk_i,
    input  logic [NUM_REFS-1:0] ref_clk_i,
    input  logic [SEL_W-1:0]    master_sel_i,
    input  logic [SEL_W-1:0]    standby_sel_i,
    input  logic                rd_en_i,
    input  logic                rd_addr_i,
    output logic [BYTE_W-1:0]   rd_data_o,
    output logic [STAT_W-1:0]   status_o
);
    localparam int unsigned PER_W = CNT_W + 1;

    typedef struct packed {
        logic [BYTE_W-1:0] hi_hold;
    } rd_t;

    rd_t r_d, r_q;

    logic [1:0]       src, rise;
    logic             smp_vld;
    ph_sample_t       smp;
    logic [PER_W-1:0] period_w;

    // index 0 = detector input A, index 1 = detector input B
    assign src[0] = meas_en_i ? ref_clk_i[master_sel_i] : fb_clk_i;
    assign src[1] = ref_clk_i[standby_sel_i];

    for (genvar g = 0; g < 2; g++) begin : g_sync
        rpm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .sig_i (src[g]),
            .rise_o(rise[g])
        );
    end

    rpm_interval #(.CNT_W(CNT_W)) u_interval (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .a_rise_i (rise[0]),
        .b_rise_i (rise[1]),
        .smp_vld_o(smp_vld),
        .smp_o    (smp),
        .period_o (period_w)
    );

    rpm_iir #(.OUT_W(STAT_W), .SHIFT(FILT_SHIFT)) u_iir (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (~meas_en_i),
        .smp_vld_i(smp_vld),
        .smp_i    (smp),
        .y_o      (status_o)
    );

    always_comb begin
        r_d = r_q;
        if (rd_en_i && !rd_addr_i) begin
            r_d.hi_hold = status_o[STAT_W-1:BYTE_W];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign rd_data_o = rd_addr_i ? r_q.hi_hold : status_o[BYTE_W-1:0];
endmodule

// File: rtl/ref_phase_meter_chk.sv
module ref_phase_meter_chk #(
    parameter int unsigned PER_W = 13
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             meas_en_i,
    input logic             rd_en_i,
    input logic             rd_addr_i,
    input logic [7:0]       rd_data_o,
    input logic [15:0]      status_o,
    input logic             smp_vld_i,
    input logic [PER_W-1:0] period_i
);
    // R7: a cleared enable empties the filter by the next cycle
    p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !meas_en_i |=> (status_o == 16'd0));

    // R4: the filtered word stays inside one half cycle either way
    p_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($signed(status_o) >= -16'sd256) && ($signed(status_o) <= 16'sd255));

    // R8: without a sample the status holds its value
    p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (meas_en_i && !smp_vld_i) |=> $stable(status_o));

    // R9: a low-byte read captures the high byte that the next high read returns
    p_capture_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && !rd_addr_i) |=> (!rd_addr_i || (rd_data_o == $past(status_o[15:8]))));

    // R5: a sample is only produced once a period has been measured
    p_armed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_vld_i |-> (period_i != '0));
endmodule

bind ref_phase_meter ref_phase_meter_chk #(.PER_W(CNT_W + 1)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .meas_en_i(meas_en_i),
    .rd_en_i  (rd_en_i),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o),
    .status_o (status_o),
    .smp_vld_i(smp_vld),
    .period_i (period_w)
);

// File: tb/tb_ref_phase_meter.sv
`timescale 1ns/1ps
module tb_ref_phase_meter;
    localparam int S    = 2;
    localparam int K    = 4;
    localparam int MAXC = 4095;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       meas_en = 1'b0;
    logic       fb_clk = 1'b0;
    logic [3:0] ref_clk = '0;
    logic [1:0] master_sel = '0;
    logic [1:0] standby_sel = '0;
    logic       rd_en = 1'b0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic [15:0] status;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ref_phase_meter dut (
        .clk_i(clk), .rst_ni(rst_n), .meas_en_i(meas_en), .fb_clk_i(fb_clk),
        .ref_clk_i(ref_clk), .master_sel_i(master_sel), .standby_sel_i(standby_sel),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .status_o(status)
    );

    // square-wave sources: period in ticks (0 = held low) and delay in ticks
    int tick = 1000;
    int per[4] = '{40, 40, 40, 40};
    int dly[4] = '{0, 5, 35, 20};
    int fb_per = 40;
    int fb_dly = 10;

    always @(negedge clk) begin
        tick <= tick + 1;
        for (int i = 0; i < 4; i++) begin
            ref_clk[i] <= (per[i] == 0) ? 1'b0 : (((tick - dly[i]) % per[i]) < per[i] / 2);
        end
        fb_clk <= ((tick - fb_dly) % fb_per) < fb_per / 2;
    end

    // behavioural reference model
    bit qa[$];
    bit qb[$];
    longint m_since, m_per, m_acc, m_lag, m_x, m_tgt;
    bit m_seen, m_armed, m_ea, m_eb, m_vld;
    logic [7:0]  m_hold;
    logic [15:0] m_o16;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_since = 0; m_per = 0; m_acc = 0; m_seen = 0; m_armed = 0; m_hold = 8'h00;
            qa.delete(); qb.delete();
            repeat (S + 2) begin qa.push_back(1'b0); qb.push_back(1'b0); end
        end else begin
            qa.push_front(meas_en ? ref_clk[master_sel] : fb_clk);
            qb.push_front(ref_clk[standby_sel]);
            m_ea = qa[S] && !qa[S+1];
            m_eb = qb[S] && !qb[S+1];
            void'(qa.pop_back());
            void'(qb.pop_back());
            m_o16 = 16'(m_acc >>> K);
            if (rd_en && !rd_addr) m_hold = m_o16[15:8];
            m_vld = m_eb && m_armed;
            if (m_vld) begin
                m_lag = m_ea ? 0 : m_since + 1;
                m_x = ((m_lag * 512) / m_per) % 512;
                if (m_x >= 256) m_x = m_x - 512;
            end
            if (!meas_en) m_acc = 0;
            else if (m_vld) begin
                m_tgt = m_x * (1 << K);
                m_acc = m_acc + ((m_tgt - m_acc) >>> K);
            end
            if (m_ea) begin
                if (m_seen) begin m_per = m_since + 1; m_armed = 1; end
                m_seen = 1;
                m_since = 0;
            end else if (m_since < MAXC) begin
                m_since = m_since + 1;
            end
        end
    end

    // per-cycle comparison against the model (R3, R6, R11 timing and value; R9 read path)
    always @(posedge clk) begin
        logic [15:0] exp_s;
        logic [7:0]  exp_r;
        #1;
        exp_s = 16'(m_acc >>> K);
        exp_r = rd_addr ? m_hold : exp_s[7:0];
        checks++;
        if (status !== exp_s) begin
            errors++;
            $display("FAIL R3/R6/R11 status model: actual %0d expected %0d at %0t",
                     $signed(status), $signed(exp_s), $time);
        end
        checks++;
        if (rd_data !== exp_r) begin
            errors++;
            $display("FAIL R9 rd_data model: actual %02h expected %02h at %0t", rd_data, exp_r, $time);
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int sval(input logic [15:0] v);
        return int'($signed(v));
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        int v;
        logic [7:0] hi_exp;
        master_sel = 2'd0;
        standby_sel = 2'd1;
        wait_cyc(4);
        #1;
        chk(status == 16'd0, "R10", "status in reset", sval(status), 0);
        rd_addr = 1'b1;
        #1;
        chk(rd_data == 8'h00, "R10", "captured byte in reset", rd_data, 0);
        @(negedge clk);
        rd_addr = 1'b0;
        rst_n = 1'b1;

        // R7: feedback and standby differ but the filter stays empty
        wait_cyc(600);
        chk(status == 16'd0, "R7", "status with mode clear", sval(status), 0);

        // R1/R3: master ref0, standby ref1 lags by 5 of 40 ticks -> 64
        meas_en = 1'b1;
        wait_cyc(6000);
        v = sval(status);
        chk(v >= 62 && v <= 64, "R3", "B lags by 1/8 cycle", v, 64);

        // R9: capture high byte, then let the status cross zero
        hi_exp = status[15:8];
        rd_en = 1'b1; rd_addr = 1'b0;
        #1;
        chk(rd_data == status[7:0], "R9", "low byte read", rd_data, status[7:0]);
        @(negedge clk);
        rd_en = 1'b0; rd_addr = 1'b1;
        standby_sel = 2'd2;   // ref2 leads ref0 by 5 ticks -> -64
        wait_cyc(6000);
        chk(status[15:8] != hi_exp, "R9", "status high byte moved", status[15:8], hi_exp);
        chk(rd_data == hi_exp, "R9", "captured high byte kept", rd_data, hi_exp);
        rd_addr = 1'b0;

        // R2: standby selection drives input B; leading B is negative
        v = sval(status);
        chk(v >= -65 && v <= -62, "R2", "B leads by 1/8 cycle", v, -64);

        // R4: half-cycle offset wraps to the negative end
        standby_sel = 2'd3;
        wait_cyc(6000);
        v = sval(status);
        chk(v >= -256 && v <= -253, "R4", "half cycle wraps", v, -256);

        // R1: master now ref1, standby ref2 lags by 30 ticks -> -128
        master_sel = 2'd1;
        standby_sel = 2'd2;
        wait_cyc(6000);
        v = sval(status);
        chk(v >= -129 && v <= -126, "R1", "master select drives A", v, -128);

        // R3: same reference on both inputs gives zero lag
        standby_sel = 2'd1;
        wait_cyc(6000);
        v = sval(status);
        chk(v >= -1 && v <= 0, "R3", "coincident edges", v, 0);

        // R7: clearing the mode empties the filter on the next cycle
        meas_en = 1'b0;
        @(negedge clk);
        chk(status == 16'd0, "R7", "clear after mode drop", sval(status), 0);

        // R5/R8: A held low after reset, B toggling -> nothing sampled
        rst_n = 1'b0;
        per[0] = 0;
        master_sel = 2'd0;
        standby_sel = 2'd1;
        meas_en = 1'b1;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(800);
        chk(status == 16'd0, "R5", "no sample without A period", sval(status), 0);

        // R5: once A runs again, samples resume toward 64
        per[0] = 40;
        wait_cyc(6000);
        v = sval(status);
        chk(v >= 62 && v <= 64, "R5", "sampling after A resumes", v, 64);

        finish_run();
    end

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule